// File: doc/BRIEF.md
# Clock Test Output Control Register

This block is a single 32-bit control word on a simple register bus. It decides whether an internal clock is sent out on an external debug clock pin and on a second general-purpose pin. Each pin picks its own source from a small vector of internal clocks. A 4-bit key field gates both pins. The key turns the clock on for only one exact code, so a stray or partial write cannot enable the pins by accident.

The same word also chooses where the clock monitor's range-detect enable comes from. It can follow a hardware-generated signal, or it can follow a bit that software writes. Only writes flagged as privileged change the word. A power-on reset returns the key and the range-detect source select to their reset values. The ordinary reset leaves those two fields as they are.

Top module: `clk_probe_ctrl`

## Requirements
- R1: A privileged write (`wr_en`=1, `wr_priv`=1) to address 0x8C updates the writable fields at the same clock edge. The writable fields are bit 26 (test), bit 25 (range-detect control), bit 24 (range-detect source select), bits 19:16 (key), bits 11:8 (general-purpose pin select) and bits 4:0 (debug pin select).
- R2: A read (`rd_en`=1 at address 0x8C) returns the word on `rd_data` one cycle later, with every bit outside mask 0x070F0F1F reading 0. A read at any other address returns 0, and a write at any other address has no effect.
- R3: A write with `wr_priv`=0 leaves the register unchanged.
- R4: The key resets to 0xA. A clock reaches either pin only while the key equals 0x5. Every other key value holds both pins low.
- R5: `por_n` low clears the whole word to 0x000A0000. `rst_n` low clears every field except the key and bit 24, which keep their values.
- R6: `rde_o` follows `hw_rde` when bit 24 is 0, and follows bit 25 when bit 24 is 1.
- R7: The debug pin also needs `pin_func`=1 to toggle. The general-purpose pin does not depend on `pin_func`.
- R8: The test bit (bit 26) is stored and read back but has no effect on any output.
- R9: Select code k drives the pin from `src_clks[k]` when k < N_SRC (4). Any higher code holds that pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | System reset, asynchronous, active low |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_priv | input | 1 | Write is privileged |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| src_clks | input | N_SRC | Candidate clocks |
| hw_rde | input | 1 | Hardware-generated range-detect enable |
| pin_func | input | 1 | Debug pin is in functional mode |
| dbg_clk_o | output | 1 | Gated clock to the debug pin |
| gp_clk_o | output | 1 | Gated clock to the general-purpose pin |
| rde_o | output | 1 | Resolved range-detect enable |

## Verification
Each result has its own due time.

- **Register contents:** a write lands at the clock edge that samples it. A read strobe puts the word on `rd_data` at the next edge. The bench therefore drives on the falling edge and compares `rd_data` on the falling edge just after the read edge.
- **Range-detect enable:** `rde_o` is combinational from the stored word, so it is checked in that same half cycle.
- **Gated pins:** these change only once the selected source clock next goes low, when the gate latch opens. After each write the bench waits 20 ns, then counts pin edges over a 200 ns window. It expects a non-zero count when the clock should pass and zero when it should not.

// File: rtl/clk_probe_ctrl.sv
module clk_probe_ctrl #(
  parameter int          N_SRC   = 4,
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  REG_OFS = 8'h8C,
  parameter logic [3:0]  KEY_ON  = 4'h5,
  parameter logic [3:0]  KEY_RST = 4'hA
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              wr_priv,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic [N_SRC-1:0]  src_clks,
  input  logic              hw_rde,
  input  logic              pin_func,
  output logic              dbg_clk_o,
  output logic              gp_clk_o,
  output logic              rde_o
);

  logic        sys_rn;
  logic        hit, wr_ok;
  logic        test_q, rctl_q, rsel_q;
  logic [3:0]  key_q, gp_sel_q;
  logic [4:0]  dbg_sel_q;
  logic [31:0] ctl_q;
  logic [31:0] src_ext;
  logic        dbg_src, gp_src, dbg_en, gp_en;
  logic        dbg_en_l, gp_en_l;

  assign sys_rn = rst_n & por_n;
  assign hit    = (addr == ADDR_W'(REG_OFS));
  assign wr_ok  = wr_en & wr_priv & hit;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      key_q  <= KEY_RST;
      rsel_q <= 1'b0;
    end else if (wr_ok) begin
      key_q  <= wr_data[19:16];
      rsel_q <= wr_data[24];
    end

  always_ff @(posedge clk or negedge sys_rn)
    if (!sys_rn) begin
      test_q    <= 1'b0;
      rctl_q    <= 1'b0;
      gp_sel_q  <= '0;
      dbg_sel_q <= '0;
    end else if (wr_ok) begin
      test_q    <= wr_data[26];
      rctl_q    <= wr_data[25];
      gp_sel_q  <= wr_data[11:8];
      dbg_sel_q <= wr_data[4:0];
    end

  assign ctl_q = {5'b0, test_q, rctl_q, rsel_q, 4'b0, key_q,
                  4'b0, gp_sel_q, 3'b0, dbg_sel_q};

  always_ff @(posedge clk or negedge sys_rn)
    if (!sys_rn) rd_data <= '0;
    else         rd_data <= (rd_en && hit) ? ctl_q : 32'h0;

  assign rde_o = rsel_q ? rctl_q : hw_rde;

  assign src_ext = 32'(src_clks);
  assign dbg_src = src_ext[dbg_sel_q];
  assign gp_src  = src_ext[{1'b0, gp_sel_q}];

  assign gp_en  = (key_q == KEY_ON);
  assign dbg_en = gp_en & pin_func;

  always_latch
    if (!dbg_src) dbg_en_l = dbg_en;

  always_latch
    if (!gp_src) gp_en_l = gp_en;

  assign dbg_clk_o = dbg_src & dbg_en_l;
  assign gp_clk_o  = gp_src & gp_en_l;

endmodule

// File: rtl/clk_probe_ctrl_chk.sv
module clk_probe_ctrl_chk #(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] REG_OFS = 8'h8C
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              wr_priv,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic [31:0]       ctl_q,
  input logic              rde_o
);
  localparam logic [31:0] WMASK = 32'h070F_0F1F;

  a_r1_priv_write: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_en && wr_priv && addr == ADDR_W'(REG_OFS)) |=> (ctl_q == ($past(wr_data) & WMASK)));

  a_r3_unpriv_hold: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_en && !wr_priv) |=> $stable(ctl_q));

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (rd_data & ~WMASK) == 32'h0);

  a_r6_sw_rde: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_en && wr_priv && addr == ADDR_W'(REG_OFS) && wr_data[24]) |=> (rde_o == $past(wr_data[25])));
endmodule

bind clk_probe_ctrl clk_probe_ctrl_chk #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
  .wr_priv(wr_priv), .wr_data(wr_data), .rd_data(rd_data), .ctl_q(ctl_q), .rde_o(rde_o));

// File: tb/sim_clk_probe_ctrl.sv
module sim_clk_probe_ctrl;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        pr;
    logic [31:0] wd;
    logic        pf;
    logic        hw;
    logic [31:0] rd;
    logic        dbg;
    logic        gp;
    logic        rde;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 32'h0005_0100, 1'b1, 1'b1, 32'h0005_0100, 1'b1, 1'b1, 1'b1},
    '{1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h070F_0F1F, 1'b0, 1'b0, 1'b1},
    '{1'b1, 32'h0105_0302, 1'b1, 1'b1, 32'h0105_0302, 1'b1, 1'b1, 1'b0},
    '{1'b0, 32'h0005_0000, 1'b0, 1'b1, 32'h0105_0302, 1'b0, 1'b1, 1'b0},
    '{1'b1, 32'h0405_0003, 1'b1, 1'b0, 32'h0405_0003, 1'b1, 1'b1, 1'b0},
    '{1'b1, 32'h0006_0001, 1'b1, 1'b1, 32'h0006_0001, 1'b0, 1'b0, 1'b1},
    '{1'b1, 32'h0005_0504, 1'b1, 1'b0, 32'h0005_0504, 1'b0, 1'b0, 1'b0},
    '{1'b1, 32'h0305_0000, 1'b1, 1'b0, 32'h0305_0000, 1'b1, 1'b1, 1'b1}
  };

  logic        clk = 0, por_n = 0, rst_n = 0;
  logic [7:0]  addr = 8'h8C;
  logic        wr_en = 0, wr_priv = 0, rd_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [3:0]  src_clks = 0;
  logic        hw_rde = 0, pin_func = 0;
  logic        dbg_clk_o, gp_clk_o, rde_o;

  int n_chk = 0, n_fail = 0;
  int dbg_cnt = 0, gp_cnt = 0;

  clk_probe_ctrl u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_priv(wr_priv), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .src_clks(src_clks), .hw_rde(hw_rde), .pin_func(pin_func),
    .dbg_clk_o(dbg_clk_o), .gp_clk_o(gp_clk_o), .rde_o(rde_o));

  always #(CLK_P/2) clk = ~clk;
  always #5  src_clks[0] = ~src_clks[0];
  always #7  src_clks[1] = ~src_clks[1];
  always #9  src_clks[2] = ~src_clks[2];
  always #11 src_clks[3] = ~src_clks[3];

  always @(posedge dbg_clk_o) dbg_cnt++;
  always @(posedge gp_clk_o)  gp_cnt++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic pr, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_priv = pr; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; addr = 8'h8C;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0; addr = 8'h8C;
    d = rd_data;
  endtask

  task automatic pins(string req, logic exp_dbg, logic exp_gp);
    #20;
    dbg_cnt = 0; gp_cnt = 0;
    #200;
    check({req, " dbg pin"}, 32'(dbg_cnt != 0), 32'(exp_dbg));
    check({req, " gp pin"},  32'(gp_cnt != 0),  32'(exp_gp));
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    #(CLK_P * 3);
    @(negedge clk); por_n = 1; rst_n = 1;

    // R4 R5: reset state
    rd(8'h8C, r); check("R5 reset word", r, 32'h000A_0000);
    hw_rde = 1; #1; check("R6 reset follows hw", 32'(rde_o), 32'h1);
    hw_rde = 0; #1; check("R6 reset follows hw low", 32'(rde_o), 32'h0);
    pin_func = 1;
    pins("R4 key 0xA off", 1'b0, 1'b0);

    foreach (VECS[i]) begin
      pin_func = VECS[i].pf; hw_rde = VECS[i].hw;
      wr(8'h8C, VECS[i].pr, VECS[i].wd);
      rd(8'h8C, r);
      check($sformatf("R1 R2 R3 R8 vec%0d read", i), r, VECS[i].rd);
      check($sformatf("R6 vec%0d rde", i), 32'(rde_o), 32'(VECS[i].rde));
      pins($sformatf("R4 R7 R9 vec%0d", i), VECS[i].dbg, VECS[i].gp);
    end

    // R2: other address
    wr(8'h8C, 1'b1, 32'h0005_0102);
    wr(8'h90, 1'b1, 32'h0000_0000);
    rd(8'h8C, r); check("R2 stray write ignored", r, 32'h0005_0102);
    rd(8'h90, r); check("R2 stray read zero", r, 32'h0);

    // R5: system reset keeps key and bit 24
    wr(8'h8C, 1'b1, 32'h0305_0102);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(8'h8C, r); check("R5 rst_n keeps key/sel", r, 32'h0105_0000);
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
    rd(8'h8C, r); check("R5 por_n full reset", r, 32'h000A_0000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule